// File: doc/BRIEF.md
# Ping-pong IN Endpoint Buffer Manager

This block holds the two transmit banks of an isochronous IN endpoint in a USB device controller and decides, on each IN request, whether the packet engine sends a bank or sends nothing. Firmware fills one bank through a byte write port and then pulses a ready strobe. The strobe marks that bank as ready and moves the firmware write side to the other bank straight away, so firmware can fill one bank while the other waits for the host.

The packet engine raises an IN request. One cycle later the block answers with either a send decision or a nothing decision. When the answer is send, the engine reads the bytes of the transmit bank by address, using the byte count the block reports. It then acknowledges the packet. The acknowledge empties that bank, moves the transmit side to the other bank, and sets a completion flag that firmware clears by writing to a clear input. The completion flag can raise an interrupt. A bus reset input returns the whole block to its idle state in one cycle.

Top module: `iso_pingpong_ep`

## Requirements
- R1: After `rst_n` is released, `cmpl_flag`, `irq`, `ovf_flag`, `send_go` and `send_none` are 0, and `fw_bank`, `tx_bank` and `tx_count` are all 0 (bank 0 is encoded as 0, bank 1 as 1).
- R2: A byte written with `fw_wr_en` is appended to the bank named by `fw_bank`. A pulse on `fw_tx_ready` marks that bank ready and toggles `fw_bank`, whatever state the transmit side is in.
- R3: An IN request that sees `ep_enable` high and the bank at `tx_bank` ready produces a one-cycle `send_go` in the following cycle. While the bank is ready, `tx_count` gives its byte count and `rd_data` returns the byte at `rd_addr`, with byte 0 being the first byte written.
- R4: An IN request that sees the bank at `tx_bank` not ready produces a one-cycle `send_none` in the following cycle. This repeats for every such request and does not change `tx_bank`.
- R5: While `ep_enable` is low, every IN request produces `send_none`, even when a bank is ready.
- R6: A `pkt_sent` pulse while the bank at `tx_bank` is ready clears that bank's ready flag and byte count, toggles `tx_bank` and sets `cmpl_flag`. A `pkt_sent` pulse while that bank is not ready has no effect.
- R7: With the default `IRQ_REG` = 0, `irq` is high exactly when `cmpl_flag` and `int_en` are both high, in the same cycle.
- R8: While `cmpl_flag` is set, firmware byte writes are discarded. A pulse on `fw_cmpl_clr` clears `cmpl_flag`, unless a `pkt_sent` in the same cycle sets it again.
- R9: A write to a bank that already holds `BANK_DEPTH` bytes is discarded and sets `ovf_flag`. `ovf_flag` stays set until a reset.
- R10: A byte write while the bank at `fw_bank` is marked ready is discarded, and that bank's contents and count stay unchanged.
- R11: A pulse on `bus_rst` clears both banks, both ready flags, both pointers, `cmpl_flag` and `ovf_flag`, so that the next IN request gets `send_none`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous clear on a detected bus reset |
| ep_enable | input | 1 | Endpoint is enabled and configured |
| fw_wr_en | input | 1 | Firmware byte write strobe |
| fw_wr_data | input | DATA_W | Firmware write byte |
| fw_tx_ready | input | 1 | Firmware marks the current write bank ready |
| fw_cmpl_clr | input | 1 | Firmware clear of the completion flag |
| int_en | input | 1 | Interrupt enable for completion |
| in_req | input | 1 | IN request addressed to this endpoint |
| rd_addr | input | AW | Byte address within the transmit bank |
| pkt_sent | input | 1 | Packet engine acknowledges the packet was sent |
| rd_data | output | DATA_W | Byte of the transmit bank at rd_addr |
| tx_count | output | CW | Byte count of the transmit bank |
| tx_bank | output | 1 | Bank the transmit side will send next |
| fw_bank | output | 1 | Bank firmware writes next |
| send_go | output | 1 | Decision pulse: send the transmit bank |
| send_none | output | 1 | Decision pulse: send nothing |
| cmpl_flag | output | 1 | Packet completion flag |
| irq | output | 1 | Completion interrupt |
| ovf_flag | output | 1 | Sticky capacity overflow |

## Verification
The hardest state to reach is the one where both banks are ready at once while the firmware pointer has wrapped back onto a bank that has not been sent yet. Only in that state can a discarded write (R10) be told apart from a write that overwrites data. The bench reaches it by filling bank 0 past its capacity, marking it ready, and then filling and marking bank 1 before any IN request. A stray byte written in that state must leave the first packet at full length and with its original last byte. Writes made while the completion flag is set are told apart from accepted ones in the same way, through the byte count and the first byte of the next packet.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;

   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_e;

   function automatic bank_e flip_bank(bank_e b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction

endpackage

// File: rtl/iso_pp_bank.sv
module iso_pp_bank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   parameter int AW     = 4,
   parameter int CW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     fill
);

   logic [DATA_W-1:0] mem [DEPTH];

   // the controller only raises wr_en below capacity, so fill stays in range
   always_ff @(posedge clk) begin
      if (wr_en) mem[fill[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fill <= '0;
      else if (clr)   fill <= '0;
      else if (wr_en) fill <= fill + 1'b1;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/iso_pp_ctrl.sv
module iso_pp_ctrl
   import iso_pp_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_rst,
   input  logic                fw_wr_en,
   input  logic                fw_tx_ready,
   input  logic                fw_cmpl_clr,
   input  logic                pkt_sent,
   input  logic [1:0][CW-1:0]  fill,
   output logic [1:0]          bank_we,
   output logic [1:0]          bank_clr,
   output logic [1:0]          rdy,
   output bank_e               fw_ptr,
   output bank_e               tx_ptr,
   output logic                cmpl,
   output logic                ovf
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic wr_open;
   logic fw_full;
   logic drain;

   // writes land only in an unready bank while no completion is pending
   assign wr_open = fw_wr_en && !cmpl && !rdy[fw_ptr];
   assign fw_full = (fill[fw_ptr] == FULL);
   assign drain   = pkt_sent && rdy[tx_ptr];

   for (genvar b = 0; b < 2; b++) begin : g_bank_ctl
      assign bank_we[b]  = wr_open && !fw_full && (fw_ptr == bank_e'(b));
      assign bank_clr[b] = bus_rst || (drain && (tx_ptr == bank_e'(b)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    rdy[b] <= 1'b0;
         else if (bank_clr[b])                          rdy[b] <= 1'b0;
         else if (fw_tx_ready && fw_ptr == bank_e'(b))  rdy[b] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fw_ptr <= BANK_A;
         tx_ptr <= BANK_A;
      end else if (bus_rst) begin
         fw_ptr <= BANK_A;
         tx_ptr <= BANK_A;
      end else begin
         if (fw_tx_ready) fw_ptr <= flip_bank(fw_ptr);
         if (drain)       tx_ptr <= flip_bank(tx_ptr);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmpl <= 1'b0;
         ovf  <= 1'b0;
      end else if (bus_rst) begin
         cmpl <= 1'b0;
         ovf  <= 1'b0;
      end else begin
         if (drain)            cmpl <= 1'b1;
         else if (fw_cmpl_clr) cmpl <= 1'b0;
         if (wr_open && fw_full) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/iso_pp_tx.sv
module iso_pp_tx (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst,
   input  logic in_req,
   input  logic ep_enable,
   input  logic tx_rdy,
   output logic send_go,
   output logic send_none
);

   logic eligible;
   assign eligible = ep_enable && tx_rdy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         send_go   <= 1'b0;
         send_none <= 1'b0;
      end else if (bus_rst) begin
         send_go   <= 1'b0;
         send_none <= 1'b0;
      end else begin
         send_go   <= in_req && eligible;
         send_none <= in_req && !eligible;
      end
   end

endmodule

// File: rtl/iso_pingpong_ep.sv
module iso_pingpong_ep
   import iso_pp_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int BANK_DEPTH = 16,
   parameter bit IRQ_REG    = 1'b0,
   localparam int AW = $clog2(BANK_DEPTH),
   localparam int CW = $clog2(BANK_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              ep_enable,
   input  logic              fw_wr_en,
   input  logic [DATA_W-1:0] fw_wr_data,
   input  logic              fw_tx_ready,
   input  logic              fw_cmpl_clr,
   input  logic              int_en,
   input  logic              in_req,
   input  logic [AW-1:0]     rd_addr,
   input  logic              pkt_sent,
   output logic [DATA_W-1:0] rd_data,
   output logic [CW-1:0]     tx_count,
   output logic              tx_bank,
   output logic              fw_bank,
   output logic              send_go,
   output logic              send_none,
   output logic              cmpl_flag,
   output logic              irq,
   output logic              ovf_flag
);

   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (BANK_DEPTH < 2 || (1 << AW) != BANK_DEPTH) begin : g_bad_depth
      $error("BANK_DEPTH must be a power of two of at least 2");
   end

   logic [1:0]             bank_we;
   logic [1:0]             bank_clr;
   logic [1:0]             bank_rdy;
   logic [1:0][CW-1:0]     bank_fill;
   logic [1:0][DATA_W-1:0] bank_rd;
   bank_e                  fw_ptr;
   bank_e                  tx_ptr;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      iso_pp_bank #(
         .DATA_W (DATA_W),
         .DEPTH  (BANK_DEPTH),
         .AW     (AW),
         .CW     (CW)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (bank_clr[b]),
         .wr_en   (bank_we[b]),
         .wr_data (fw_wr_data),
         .rd_addr (rd_addr),
         .rd_data (bank_rd[b]),
         .fill    (bank_fill[b])
      );
   end

   iso_pp_ctrl #(
      .DEPTH (BANK_DEPTH),
      .CW    (CW)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_rst     (bus_rst),
      .fw_wr_en    (fw_wr_en),
      .fw_tx_ready (fw_tx_ready),
      .fw_cmpl_clr (fw_cmpl_clr),
      .pkt_sent    (pkt_sent),
      .fill        (bank_fill),
      .bank_we     (bank_we),
      .bank_clr    (bank_clr),
      .rdy         (bank_rdy),
      .fw_ptr      (fw_ptr),
      .tx_ptr      (tx_ptr),
      .cmpl        (cmpl_flag),
      .ovf         (ovf_flag)
   );

   iso_pp_tx u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rst   (bus_rst),
      .in_req    (in_req),
      .ep_enable (ep_enable),
      .tx_rdy    (bank_rdy[tx_ptr]),
      .send_go   (send_go),
      .send_none (send_none)
   );

   assign rd_data  = bank_rd[tx_ptr];
   assign tx_count = bank_fill[tx_ptr];
   assign tx_bank  = tx_ptr;
   assign fw_bank  = fw_ptr;

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= cmpl_flag && int_en;
      end
   end else begin : g_irq_comb
      assign irq = cmpl_flag && int_en;
   end

endmodule

// File: rtl/iso_pp_checker.sv
module iso_pp_checker #(
   parameter int CW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_rst,
   input logic          ep_enable,
   input logic          in_req,
   input logic          pkt_sent,
   input logic          fw_tx_ready,
   input logic          send_go,
   input logic          send_none,
   input logic          cmpl_flag,
   input logic          ovf_flag,
   input logic          fw_bank,
   input logic          tx_bank,
   input logic [CW-1:0] tx_count,
   input logic [1:0]    rdy
);

   AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
      !(send_go && send_none)); // R3

   AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      in_req && !bus_rst |=> (send_go || send_none)); // R3

   AST_NOTHING_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
      in_req && !bus_rst && !rdy[tx_bank] |=> send_none && $stable(tx_bank)); // R4

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_req && !bus_rst && !ep_enable |=> send_none); // R5

   AST_FW_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      fw_tx_ready && !bus_rst |=> fw_bank != $past(fw_bank)); // R2

   AST_ACK_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sent && !bus_rst && rdy[tx_bank] |=> cmpl_flag && tx_bank != $past(tx_bank)); // R6

   AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_sent && !bus_rst && !rdy[tx_bank] && !fw_tx_ready |=> $stable(tx_bank) && $stable(rdy)); // R6

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !bus_rst |=> ovf_flag); // R9

   AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !cmpl_flag && !ovf_flag && !fw_bank && !tx_bank && rdy == 2'b00 && tx_count == '0); // R11

endmodule

bind iso_pingpong_ep iso_pp_checker #(.CW(CW)) u_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_rst     (bus_rst),
   .ep_enable   (ep_enable),
   .in_req      (in_req),
   .pkt_sent    (pkt_sent),
   .fw_tx_ready (fw_tx_ready),
   .send_go     (send_go),
   .send_none   (send_none),
   .cmpl_flag   (cmpl_flag),
   .ovf_flag    (ovf_flag),
   .fw_bank     (fw_bank),
   .tx_bank     (tx_bank),
   .tx_count    (tx_count),
   .rdy         (bank_rdy)
);

// File: tb/iso_pingpong_ep_bench.sv
`timescale 1ns/100ps
module iso_pingpong_ep_bench;

   localparam int DW    = 8;
   localparam int DEPTH = 16;
   localparam int AW    = $clog2(DEPTH);
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_rst = 1'b0;
   logic          ep_enable = 1'b0;
   logic          fw_wr_en = 1'b0;
   logic [DW-1:0] fw_wr_data = '0;
   logic          fw_tx_ready = 1'b0;
   logic          fw_cmpl_clr = 1'b0;
   logic          int_en = 1'b0;
   logic          in_req = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          pkt_sent = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] tx_count;
   logic          tx_bank, fw_bank, send_go, send_none, cmpl_flag, irq, ovf_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit exp_q[$];

   always #2 clk = ~clk;

   iso_pingpong_ep #(.DATA_W(DW), .BANK_DEPTH(DEPTH)) u_iso_pingpong_ep (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .ep_enable(ep_enable),
      .fw_wr_en(fw_wr_en), .fw_wr_data(fw_wr_data), .fw_tx_ready(fw_tx_ready),
      .fw_cmpl_clr(fw_cmpl_clr), .int_en(int_en), .in_req(in_req),
      .rd_addr(rd_addr), .pkt_sent(pkt_sent), .rd_data(rd_data),
      .tx_count(tx_count), .tx_bank(tx_bank), .fw_bank(fw_bank),
      .send_go(send_go), .send_none(send_none), .cmpl_flag(cmpl_flag),
      .irq(irq), .ovf_flag(ovf_flag)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: compare each decision pulse against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && (send_go || send_none)) begin
         if (exp_q.size() == 0) chk("R3 unexpected decision", 1, 0);
         else begin
            bit e;
            e = exp_q.pop_front();
            chk("R3/R4/R5 decision send_go", int'(send_go), int'(e));
         end
      end
   end

   // all tasks start and end one time unit after a rising edge
   task automatic wr_byte(logic [DW-1:0] d);
      fw_wr_data = d; fw_wr_en = 1'b1;
      @(posedge clk); #1 fw_wr_en = 1'b0;
   endtask

   task automatic mark_ready();
      fw_tx_ready = 1'b1;
      @(posedge clk); #1 fw_tx_ready = 1'b0;
   endtask

   task automatic clr_cmpl();
      fw_cmpl_clr = 1'b1;
      @(posedge clk); #1 fw_cmpl_clr = 1'b0;
   endtask

   task automatic ack_sent();
      pkt_sent = 1'b1;
      @(posedge clk); #1 pkt_sent = 1'b0;
   endtask

   task automatic token(bit expect_go);
      exp_q.push_back(expect_go);
      in_req = 1'b1;
      @(posedge clk); #1 in_req = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic read_at(int a, int exp, string req);
      rd_addr = AW'(a);
      #0.5 chk(req, int'(rd_data), exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("R1 cmpl_flag", int'(cmpl_flag), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 ovf_flag", int'(ovf_flag), 0);
      chk("R1 fw_bank", int'(fw_bank), 0);
      chk("R1 tx_bank", int'(tx_bank), 0);
      chk("R1 tx_count", int'(tx_count), 0);
      chk("R1 decisions", int'(send_go | send_none), 0);

      // R2 fill bank 0, mark ready; R5 endpoint disabled answers nothing
      for (int i = 0; i < 3; i++) wr_byte(DW'(8'hA0 + i));
      mark_ready();
      chk("R2 fw_bank toggled", int'(fw_bank), 1);
      token(1'b0); // R5

      // R3 enabled: bank 0 is sent
      ep_enable = 1'b1;
      int_en = 1'b1;
      token(1'b1);
      chk("R3 tx_count", int'(tx_count), 3);
      for (int i = 0; i < 3; i++) read_at(i, 8'hA0 + i, "R3 rd_data");
      @(posedge clk); #1;
      ack_sent();
      chk("R6 cmpl_flag set", int'(cmpl_flag), 1);
      chk("R6 tx_bank toggled", int'(tx_bank), 1);
      chk("R7 irq enabled", int'(irq), 1);
      int_en = 1'b0;
      #0.5 chk("R7 irq masked", int'(irq), 0);

      // R4 bank 1 not ready: repeated nothing
      token(1'b0);
      token(1'b0);
      chk("R4 tx_bank held", int'(tx_bank), 1);

      // R8 write while completion pending is dropped
      wr_byte(8'hEE);
      clr_cmpl();
      chk("R8 cmpl cleared", int'(cmpl_flag), 0);
      wr_byte(8'h11);
      wr_byte(8'h22);
      mark_ready();
      chk("R2 fw_bank back to 0", int'(fw_bank), 0);
      token(1'b1);
      chk("R8 tx_count", int'(tx_count), 2);
      read_at(0, 8'h11, "R8 first byte");
      @(posedge clk); #1;
      ack_sent();
      chk("R6 tx_bank to 0", int'(tx_bank), 0);

      // R6 stray acknowledge on an unready bank
      clr_cmpl();
      ack_sent();
      chk("R6 stray ack tx_bank", int'(tx_bank), 0);
      chk("R6 stray ack cmpl", int'(cmpl_flag), 0);

      // R9 overflow on bank 0
      for (int i = 0; i < DEPTH + 2; i++) wr_byte(DW'(8'h40 + i));
      chk("R9 ovf_flag", int'(ovf_flag), 1);
      mark_ready();
      wr_byte(8'h55);
      mark_ready();
      // R10 fw_bank is back on ready bank 0: this byte is dropped
      wr_byte(8'h77);
      token(1'b1);
      chk("R9/R10 tx_count full", int'(tx_count), DEPTH);
      read_at(DEPTH - 1, 8'h40 + DEPTH - 1, "R10 last byte kept");
      read_at(0, 8'h40, "R9 first byte");
      @(posedge clk); #1;
      ack_sent();
      clr_cmpl();
      token(1'b1);
      chk("R2 bank 1 count", int'(tx_count), 1);
      read_at(0, 8'h55, "R2 bank 1 byte");
      @(posedge clk); #1;
      ack_sent();
      chk("R9 ovf sticky", int'(ovf_flag), 1);

      // R11 bus reset
      clr_cmpl();
      wr_byte(8'h01);
      wr_byte(8'h02);
      mark_ready();
      bus_rst = 1'b1;
      @(posedge clk); #1 bus_rst = 1'b0;
      chk("R11 fw_bank", int'(fw_bank), 0);
      chk("R11 tx_bank", int'(tx_bank), 0);
      chk("R11 cmpl_flag", int'(cmpl_flag), 0);
      chk("R11 ovf_flag", int'(ovf_flag), 0);
      chk("R11 tx_count", int'(tx_count), 0);
      token(1'b0);

      repeat (2) @(posedge clk);
      chk("R3 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule